// File: doc/BRIEF.md
# Fractional-Nanosecond Time-of-Day Counter

This block keeps a free-running time of day for precision time protocol use. It counts in the clock domain it sits in. The time is stored as a 64-bit count of whole nanoseconds plus a 32-bit binary fraction of a nanosecond. While counting is enabled, a programmable increment is added to the time on every clock cycle. The increment is a 32.32 fixed-point number of nanoseconds. It normally equals the clock period: (10^9 · 2^32) divided by the clock rate in Hz.

Software reaches the block through a 64-bit register port. It can turn counting on and off, rewrite the increment at run time to steer the rate, load either half of the time directly, and read everything back. The parts-per-million arithmetic that turns a frequency correction into a new increment is done by software, not by this block.

Register map, with byte offsets that are parameters:

| Offset | Name | Write | Read |
|---|---|---|---|
| 0xF00 | control | bit 0 is the run bit | run bit in bit 0, zeros elsewhere |
| 0xF08 | fraction | bits 63:32 load the fraction | fraction in bits 63:32, zeros in bits 31:0 |
| 0xF10 | nanoseconds | loads the whole-nanosecond count | whole-nanosecond count |
| 0xF18 | increment | loads the 32.32 increment | the 32.32 increment |

Top module: `ptp_tod_counter`

## Requirements
- R1: After a synchronous active-low reset, the nanosecond count, the fraction and the run bit are zero, and the increment register holds 0x1_4000_0000 (1.25 ns, the period of an 800 MHz clock).
- R2: The run bit is bit 0 of the control register at offset 0xF00. While it is clear, the time holds its value. The control register reads back with the run bit in bit 0 and zeros in every other bit, whatever was written to them.
- R3: At each rising clock edge while the run bit is set, the 32.32 increment from the register at offset 0xF18 is added to the 96-bit time {nanoseconds, fraction}. Bits 63:32 of the increment are whole nanoseconds and bits 31:0 are the fraction.
- R4: A carry out of the fraction adds one to the nanosecond count at the same edge. The nanosecond count wraps modulo 2^64.
- R5: A write to the increment register is used from the edge after the write edge onward. The write edge itself still adds the old increment, and the accumulated fraction is kept. The register reads back the value last written.
- R6: A write to offset 0xF10 loads the nanosecond count from the write data. A write to offset 0xF08 loads the fraction from write-data bits 63:32. No increment is added at a load edge, and the half that is not written keeps its value.
- R7: Reads are combinational from the read address. Offset 0xF10 returns the nanosecond count. Offset 0xF08 returns the fraction in bits 63:32 with zeros in bits 31:0. Any address outside the map returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that paces the counter |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 64 | Write data |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 64 | Read data, combinational from rd_addr |

## Verification
The bench runs the counter once for every clock multiplier from 1 to 63 of a 50 MHz base. For each one it computes the nominal increment arithmetically and starts from a different preset time. The expected 96-bit result is the preset time plus the number of edges times the increment, so a fraction carry that is dropped or arrives one cycle late shows up as a nanosecond shortfall. Directed cases cover a wrap of the nanosecond count, an increment change in the middle of a run (a design that applies the new value at the write edge, or clears the fraction, ends up off by a predictable amount), and loads while the counter is running (a design that also accumulates at a load edge reads back one step high). Further checks cover holding while disabled, control bits that must not stick, and unmapped reads.

// File: rtl/ptp_tod_pkg.sv
// Package: shared widths and the decoded write-select type for the
// time-of-day counter. Assumes a 64-bit register data path.
package ptp_tod_pkg;
    localparam int DATA_W = 64;

    // One-hot decode of a register write
    typedef struct packed {
        logic ctrl;
        logic frac;
        logic ns;
        logic inc;
    } wsel_t;
endpackage

// File: rtl/ptp_tod_regs.sv
// Module: control and increment registers plus the write decoder.
// Decodes wr_addr against the four offsets and holds the run bit and the
// 32.32 increment. Gives the accumulator one-cycle load strobes for the
// time halves. Assumes at most one write per cycle.
module ptp_tod_regs
    import ptp_tod_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter int          INC_W    = 64,
    parameter logic [63:0] INC_RST  = 64'h0000_0001_4000_0000,
    parameter int          OFF_CTRL = 'hF00,
    parameter int          OFF_FRAC = 'hF08,
    parameter int          OFF_NS   = 'hF10,
    parameter int          OFF_INC  = 'hF18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wsel_t             wsel,
    output logic              run_q,
    output logic [INC_W-1:0]  inc_q
);
    // Decode a write into a one-hot select
    always_comb begin
        wsel      = '0;
        wsel.ctrl = wr_en && (wr_addr == ADDR_W'(OFF_CTRL));
        wsel.frac = wr_en && (wr_addr == ADDR_W'(OFF_FRAC));
        wsel.ns   = wr_en && (wr_addr == ADDR_W'(OFF_NS));
        wsel.inc  = wr_en && (wr_addr == ADDR_W'(OFF_INC));
    end

    // Hold the run bit and the increment value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            inc_q <= INC_W'(INC_RST);
        end else begin
            if (wsel.ctrl) run_q <= wr_data[0];
            if (wsel.inc)  inc_q <= wr_data[INC_W-1:0];
        end
    end

    // One cycle of reset always leaves the default increment
    assert_inc_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (inc_q == INC_W'(INC_RST)) && !run_q);
endmodule

// File: rtl/ptp_tod_accum.sv
// Module: fractional time accumulator. Adds a whole.fraction increment to
// {ns, frac} on each enabled edge, with the fraction carry going into ns.
// A load of either half wins over accumulation at that edge.
// Assumes NS_W >= INT_W.
module ptp_tod_accum #(
    parameter int NS_W   = 64,
    parameter int FRAC_W = 32,
    parameter int INT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [INT_W-1:0]  inc_int,
    input  logic [FRAC_W-1:0] inc_frac,
    input  logic              ld_ns,
    input  logic [NS_W-1:0]   ld_ns_val,
    input  logic              ld_frac,
    input  logic [FRAC_W-1:0] ld_frac_val,
    output logic [NS_W-1:0]   ns_q,
    output logic [FRAC_W-1:0] frac_q
);
    logic              carry;
    logic [FRAC_W-1:0] frac_sum;
    logic [NS_W-1:0]   ns_sum;

    // Next time value: fraction add, then carry into nanoseconds
    always_comb begin
        {carry, frac_sum} = {1'b0, frac_q} + {1'b0, inc_frac};
        ns_sum            = ns_q + NS_W'(inc_int) + NS_W'(carry);
    end

    // Time registers: reset, then load, then accumulate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q   <= '0;
            frac_q <= '0;
        end else if (ld_ns || ld_frac) begin
            if (ld_ns)   ns_q   <= ld_ns_val;
            if (ld_frac) frac_q <= ld_frac_val;
        end else if (run) begin
            ns_q   <= ns_sum;
            frac_q <= frac_sum;
        end
    end

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ld_ns && !ld_frac) |=> $stable(ns_q) && $stable(frac_q));

    assert_ns_step_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ld_ns && !ld_frac) |=>
        ((ns_q - $past(ns_q) - NS_W'($past(inc_int))) <= NS_W'(1)));

    assert_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ns |=> ns_q == $past(ld_ns_val));

    assert_frac_kept_on_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ns && !ld_frac) |=> $stable(frac_q));
endmodule

// File: rtl/ptp_tod_rdmux.sv
// Module: combinational read multiplexer for the register map.
// The fraction is placed at the top of the 64-bit word. Unmapped
// addresses read as zero.
module ptp_tod_rdmux
    import ptp_tod_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NS_W     = 64,
    parameter int FRAC_W   = 32,
    parameter int INC_W    = 64,
    parameter int OFF_CTRL = 'hF00,
    parameter int OFF_FRAC = 'hF08,
    parameter int OFF_NS   = 'hF10,
    parameter int OFF_INC  = 'hF18
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              run_q,
    input  logic [INC_W-1:0]  inc_q,
    input  logic [NS_W-1:0]   ns_q,
    input  logic [FRAC_W-1:0] frac_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - FRAC_W;

    // Select the addressed register
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFF_CTRL))      rd_data = DATA_W'(run_q);
        else if (rd_addr == ADDR_W'(OFF_FRAC)) rd_data = {frac_q, {PAD_W{1'b0}}};
        else if (rd_addr == ADDR_W'(OFF_NS))   rd_data = DATA_W'(ns_q);
        else if (rd_addr == ADDR_W'(OFF_INC))  rd_data = DATA_W'(inc_q);
    end
endmodule

// File: rtl/ptp_tod_counter.sv
// Module: top of the fractional-nanosecond time-of-day counter.
// Connects the register decoder, the accumulator and the read mux.
// Assumes a 32.32 increment and a 64-bit nanosecond count.
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NS_W     = 64,
    parameter int FRAC_W   = 32,
    parameter int OFF_CTRL = 'hF00,
    parameter int OFF_FRAC = 'hF08,
    parameter int OFF_NS   = 'hF10,
    parameter int OFF_INC  = 'hF18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data
);
    localparam int INC_W = DATA_W;
    localparam int INT_W = INC_W - FRAC_W;

    wsel_t             wsel;
    logic              run_q;
    logic [INC_W-1:0]  inc_q;
    logic [NS_W-1:0]   ns_q;
    logic [FRAC_W-1:0] frac_q;

    ptp_tod_regs #(
        .ADDR_W(ADDR_W), .INC_W(INC_W), .INC_RST(64'h0000_0001_4000_0000),
        .OFF_CTRL(OFF_CTRL), .OFF_FRAC(OFF_FRAC), .OFF_NS(OFF_NS), .OFF_INC(OFF_INC)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wsel(wsel), .run_q(run_q), .inc_q(inc_q)
    );

    ptp_tod_accum #(
        .NS_W(NS_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .run(run_q),
        .inc_int(inc_q[INC_W-1:FRAC_W]), .inc_frac(inc_q[FRAC_W-1:0]),
        .ld_ns(wsel.ns), .ld_ns_val(wr_data[NS_W-1:0]),
        .ld_frac(wsel.frac), .ld_frac_val(wr_data[DATA_W-1:DATA_W-FRAC_W]),
        .ns_q(ns_q), .frac_q(frac_q)
    );

    ptp_tod_rdmux #(
        .ADDR_W(ADDR_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(INC_W),
        .OFF_CTRL(OFF_CTRL), .OFF_FRAC(OFF_FRAC), .OFF_NS(OFF_NS), .OFF_INC(OFF_INC)
    ) u_rdmux (
        .rd_addr(rd_addr), .run_q(run_q), .inc_q(inc_q),
        .ns_q(ns_q), .frac_q(frac_q), .rd_data(rd_data)
    );

    // New increment is visible in the register one edge after its write (R5)
    assert_inc_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(OFF_INC)) |=> inc_q == $past(wr_data));
endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
    localparam logic [11:0] A_CTRL = 12'hF00;
    localparam logic [11:0] A_FRAC = 12'hF08;
    localparam logic [11:0] A_NS   = 12'hF10;
    localparam logic [11:0] A_INC  = 12'hF18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [63:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ptp_tod_counter u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; spans exactly one rising edge
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_time(input string req, input logic [95:0] exp);
        logic [63:0] v;
        rd(A_NS, v);   chk(req, v, exp[95:32]);
        rd(A_FRAC, v); chk(req, v, {exp[31:0], 32'h0});
    endtask

    // Preset time, run n edges after enabling, then disable (one more edge)
    task automatic run(input string req, input logic [63:0] s_ns, input logic [31:0] s_fr,
                       input logic [63:0] inc, input int n);
        logic [95:0] e;
        wr(A_CTRL, 64'h0);
        wr(A_NS, s_ns);
        wr(A_FRAC, {s_fr, 32'h0});
        wr(A_INC, inc);
        wr(A_CTRL, 64'h1);
        repeat (n) @(negedge clk);
        wr(A_CTRL, 64'h0);
        e = {s_ns, s_fr} + 96'(n + 1) * {32'h0, inc};
        check_time(req, e);
    endtask

    initial begin
        logic [63:0] v;
        logic [95:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_NS, v);   chk("R1", v, 64'h0);
        rd(A_FRAC, v); chk("R1", v, 64'h0);
        rd(A_CTRL, v); chk("R1", v, 64'h0);
        rd(A_INC, v);  chk("R1", v, 64'h0000_0001_4000_0000);

        // R2 disabled: time holds
        repeat (6) @(negedge clk);
        rd(A_NS, v); chk("R2", v, 64'h0);

        // R2 control readback keeps only bit 0
        wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(A_CTRL, v); chk("R2", v, 64'h0);
        wr(A_CTRL, 64'hA5A5_0000_0000_0001);
        rd(A_CTRL, v); chk("R2", v, 64'h1);
        wr(A_CTRL, 64'h0);

        // R3/R4 sweep over every multiplier of a 50 MHz base
        for (int m = 1; m < 64; m++) begin
            logic [63:0] inc;
            inc = (64'd1000000000 << 32) / (64'd50000000 * 64'(m));
            run("R3", 64'(m) * 64'h0123_4567_89AB_CDEF, 32'(m) * 32'h9E37_79B9, inc, 5 + (m % 7));
        end

        // R4 fraction carries
        run("R4", 64'd100, 32'h0, 64'h0000_0000_8000_0000, 3);
        run("R4", 64'd7, 32'hFFFF_FFFF, 64'h0000_0000_0000_0001, 0);
        run("R4", 64'd0, 32'h1234_5678, 64'h0000_0000_FFFF_FFFF, 9);

        // R4 nanosecond wrap
        run("R4", 64'hFFFF_FFFF_FFFF_FFFF, 32'hC000_0000, 64'h0000_0000_4000_0000, 0);
        run("R4", 64'hFFFF_FFFF_FFFF_FFFD, 32'h8000_0000, 64'h0000_0002_8000_0000, 3);

        // R2 hold after a run
        repeat (5) @(negedge clk);
        check_time("R2", {64'hFFFF_FFFF_FFFF_FFFD, 32'h8000_0000} + 96'd4 * 96'h2_8000_0000);

        // R5 increment change in the middle of a run
        wr(A_CTRL, 64'h0);
        wr(A_NS, 64'd1000);
        wr(A_FRAC, {32'h4000_0000, 32'h0});
        wr(A_INC, 64'h0000_0001_4000_0000);
        wr(A_CTRL, 64'h1);
        repeat (4) @(negedge clk);
        wr(A_INC, 64'h0000_0000_A000_0000);
        rd(A_INC, v); chk("R5", v, 64'h0000_0000_A000_0000);
        repeat (6) @(negedge clk);
        wr(A_CTRL, 64'h0);
        e = {64'd1000, 32'h4000_0000} + 96'd5 * 96'h1_4000_0000 + 96'd7 * 96'h0_A000_0000;
        check_time("R5", e);

        // R6 loads win over accumulation while running
        wr(A_NS, 64'd0);
        wr(A_FRAC, 64'h0);
        wr(A_INC, 64'h0000_0001_0000_0000);
        wr(A_CTRL, 64'h1);
        repeat (3) @(negedge clk);
        wr(A_NS, 64'd5000);
        check_time("R6", {64'd5000, 32'h0});
        @(negedge clk);
        check_time("R6", {64'd5001, 32'h0});
        wr(A_FRAC, {32'h8000_0000, 32'hFFFF_FFFF});
        check_time("R6", {64'd5001, 32'h8000_0000});
        @(negedge clk);
        check_time("R6", {64'd5002, 32'h8000_0000});
        wr(A_CTRL, 64'h0);

        // R7 unmapped addresses read zero
        rd(12'hF20, v); chk("R7", v, 64'h0);
        rd(12'h000, v); chk("R7", v, 64'h0);
        rd(12'hF04, v); chk("R7", v, 64'h0);

        // R1 reset again in the middle of activity
        wr(A_CTRL, 64'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(A_INC, v); chk("R1", v, 64'h0000_0001_4000_0000);
        rd(A_CTRL, v); chk("R1", v, 64'h0);
        check_time("R1", 96'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule